// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Register Controller

This block gathers interrupt sources of several kinds into three 8-bit banks: two normal-priority banks (A and B) and one fast bank (F). Each bank has a status view, a request view (status gated by a mask) and a writable mask. The sources are of several kinds. Some are level inputs, either active-low or active-high. Two are latched on a falling or a rising edge. One flag is set by reset. Two are set by timer-reload pulses. Two bit positions always read as one. The block drives two active-low outputs, `irq_n` for banks A and B and `fiq_n` for bank F.

Software reaches the block through a small synchronous register port: a 5-bit word address, single-cycle read and write strobes, and 8-bit data. Read data is registered. Only the latched bits A[6:2] hold state, and software clears them by writing ones to the clear address. Bank A bits 0 and 1, bank B bits 0 to 5 and all of bank F follow their inputs with no latching. There is no state machine. All control is a register decode plus set/clear latches.

Top module: `irqc_top`

## Requirements
- R1: Word addresses are: control 0x00, A status/request/mask 0x04/0x05/0x06, B 0x08/0x09/0x0A, F 0x0C/0x0D/0x0E. A read strobe at a clock edge puts the addressed value on `bus_rdata` after that edge. Unmapped addresses read 0x00.
- R2: All three masks reset to 0x00 and read back the last value written to them.
- R3: Each request register equals its status register ANDed with its mask register.
- R4: `irq_n` is low exactly when request A or request B was non-zero at the previous clock edge.
- R5: `fiq_n` is low exactly when request F was non-zero at the previous clock edge.
- R6: A falling edge on `edge_fall_in` sets status A bit 2, after a two-flop synchronizer. The bit stays set while the input stays low, and a single edge sets it only once.
- R7: A rising edge on `edge_rise_in` sets status A bit 3, after a two-flop synchronizer.
- R8: Status A bit 4 is set by reset and stays set until it is cleared.
- R9: A one-cycle pulse on `tmr_reload[0]` sets status A bit 5, and a pulse on `tmr_reload[1]` sets status A bit 6.
- R10: Writing to 0x05 clears each of status A bits 2 to 6 for which the data bit is 1. Data bits 0, 1 and 7 have no effect. A set in the same cycle wins over the clear.
- R11: Status A bits 0 and 1 are the inverse of `lvl_a_n[1:0]`, and bit 7 reads 1. Status B bits 0 to 5 are the inverse of `lvl_b_n`, bit 6 is `ser_tx_done` and bit 7 is `ser_rx_done`.
- R12: Status F bits 0 and 1 are `fiq_hi`, bits 2 to 6 are the inverse of `fiq_lo_n`, and bit 7 reads 1.
- R13: Control bit 2 reads the synchronized level of `edge_fall_in` and bit 3 that of `edge_rise_in`. Its other bits read 0. Writes to status, request (other than 0x05) and control addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lvl_a_n | input | 2 | Active-low level sources, bank A bits 0-1 |
| edge_fall_in | input | 1 | Falling-edge source, bank A bit 2 |
| edge_rise_in | input | 1 | Rising-edge source, bank A bit 3 |
| tmr_reload | input | 2 | Timer reload pulses, bank A bits 5-6 |
| lvl_b_n | input | 6 | Active-low level sources, bank B bits 0-5 |
| ser_tx_done | input | 1 | Serial transmit done, bank B bit 6 |
| ser_rx_done | input | 1 | Serial receive done, bank B bit 7 |
| fiq_hi | input | 2 | Active-high sources, bank F bits 0-1 |
| fiq_lo_n | input | 5 | Active-low sources, bank F bits 2-6 |
| irq_n | output | 1 | Active-low normal interrupt |
| fiq_n | output | 1 | Active-low fast interrupt |

## Verification
The assertions assume that `tmr_reload` pulses are synchronous to `clk`. They also assume that the bus strobes are sampled only at clock edges, and that every register starts from its reset value. The edge inputs are taken as asynchronous but held for at least three cycles, so that the synchronizer sees each level. The stimulus changes every input half a period away from the rising edge. It holds each edge level for several cycles and pulses the timers for exactly one cycle. This keeps the bench's event model and the design in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int LAT_LO = 2;
    localparam int LAT_HI = 6;
    localparam int LAT_W  = LAT_HI - LAT_LO + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t AD_CTRL  = 5'h00;
    localparam addr_t AD_A_STA = 5'h04;
    localparam addr_t AD_A_REQ = 5'h05;
    localparam addr_t AD_A_MSK = 5'h06;
    localparam addr_t AD_B_STA = 5'h08;
    localparam addr_t AD_B_REQ = 5'h09;
    localparam addr_t AD_B_MSK = 5'h0A;
    localparam addr_t AD_F_STA = 5'h0C;
    localparam addr_t AD_F_REQ = 5'h0D;
    localparam addr_t AD_F_MSK = 5'h0E;
endpackage

// File: rtl/irqc_edge_catch.sv
module irqc_edge_catch #(
    parameter bit RISING      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level_sync,
    output logic pulse
);
    localparam logic IDLE = RISING ? 1'b0 : 1'b1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {SYNC_STAGES{IDLE}};
            prev  <= IDLE;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], raw};
            prev  <= chain[SYNC_STAGES-1];
        end
    end

    assign level_sync = chain[SYNC_STAGES-1];

    generate
        if (RISING) begin : g_rise
            assign pulse = level_sync & ~prev;
        end else begin : g_fall
            assign pulse = ~level_sync & prev;
        end
    endgenerate

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R6
endmodule

// File: rtl/irqc_lat_bank.sv
module irqc_lat_bank #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] lat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= RST_VAL;
        else        lat <= (lat & ~clr_vec) | set_vec;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & $past(set_vec)) == $past(set_vec))); // R9
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & $past(clr_vec & ~set_vec)) == '0)); // R10
    AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & ~$past(lat) & ~$past(set_vec)) == '0)); // R8
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [1:0]  lvl_a_n,
    input  logic        edge_fall_in,
    input  logic        edge_rise_in,
    input  logic [1:0]  tmr_reload,
    input  logic [5:0]  lvl_b_n,
    input  logic        ser_tx_done,
    input  logic        ser_rx_done,
    input  logic [1:0]  fiq_hi,
    input  logic [4:0]  fiq_lo_n,
    output logic        irq_n,
    output logic        fiq_n
);
    localparam logic [LAT_W-1:0] LAT_RST = 5'b00100;

    logic fall_lvl, fall_pulse, rise_lvl, rise_pulse;
    logic [LAT_W-1:0] lat_set, lat_clr, lat_q;
    word_t msk_a, msk_b, msk_f;
    word_t sta_a, sta_b, sta_f;
    word_t req_a, req_b, req_f;
    word_t rd_mux;

    irqc_edge_catch #(.RISING(1'b0), .SYNC_STAGES(2)) i_fall (
        .clk(clk), .rst_n(rst_n), .raw(edge_fall_in),
        .level_sync(fall_lvl), .pulse(fall_pulse));

    irqc_edge_catch #(.RISING(1'b1), .SYNC_STAGES(2)) i_rise (
        .clk(clk), .rst_n(rst_n), .raw(edge_rise_in),
        .level_sync(rise_lvl), .pulse(rise_pulse));

    assign lat_set = {tmr_reload[1], tmr_reload[0], 1'b0, rise_pulse, fall_pulse};
    assign lat_clr = (bus_wr && bus_addr == AD_A_REQ) ? bus_wdata[LAT_HI:LAT_LO] : '0;

    irqc_lat_bank #(.W(LAT_W), .RST_VAL(LAT_RST)) i_lat (
        .clk(clk), .rst_n(rst_n), .set_vec(lat_set), .clr_vec(lat_clr), .lat(lat_q));

    assign sta_a = {1'b1, lat_q, ~lvl_a_n};
    assign sta_b = {ser_rx_done, ser_tx_done, ~lvl_b_n};
    assign sta_f = {1'b1, ~fiq_lo_n, fiq_hi};
    assign req_a = sta_a & msk_a;
    assign req_b = sta_b & msk_b;
    assign req_f = sta_f & msk_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_a <= '0;
            msk_b <= '0;
            msk_f <= '0;
        end else if (bus_wr) begin
            if (bus_addr == AD_A_MSK) msk_a <= bus_wdata;
            if (bus_addr == AD_B_MSK) msk_b <= bus_wdata;
            if (bus_addr == AD_F_MSK) msk_f <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            AD_CTRL:  rd_mux = {4'b0000, rise_lvl, fall_lvl, 2'b00};
            AD_A_STA: rd_mux = sta_a;
            AD_A_REQ: rd_mux = req_a;
            AD_A_MSK: rd_mux = msk_a;
            AD_B_STA: rd_mux = sta_b;
            AD_B_REQ: rd_mux = req_b;
            AD_B_MSK: rd_mux = msk_b;
            AD_F_STA: rd_mux = sta_f;
            AD_F_REQ: rd_mux = req_f;
            AD_F_MSK: rd_mux = msk_f;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq_n     <= 1'b1;
            fiq_n     <= 1'b1;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;
            irq_n <= ~(|req_a | |req_b);
            fiq_n <= ~(|req_f);
        end
    end

    AST_IRQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !($past(|(sta_a & msk_a)) || $past(|(sta_b & msk_b))))); // R4
    AST_FIQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_n == !$past(|(sta_f & msk_f)))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(msk_a) && $stable(msk_b) && $stable(msk_f)); // R2
    AST_ALWAYS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        sta_a[7] && sta_f[7]); // R11
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] lvl_a_n = 2'b11;
    logic edge_fall_in = 1'b1, edge_rise_in = 1'b0;
    logic [1:0] tmr_reload = 2'b00;
    logic [5:0] lvl_b_n = 6'h3F;
    logic ser_tx_done = 1'b0, ser_rx_done = 1'b0;
    logic [1:0] fiq_hi = 2'b00;
    logic [4:0] fiq_lo_n = 5'h1F;
    logic irq_n, fiq_n;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [7:0] m_lat = 8'h10;
    logic [7:0] m_ma = 0, m_mb = 0, m_mf = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    irqc_top i_irqc_top (.*);

    function automatic logic [7:0] e_sta_a();
        return {1'b1, m_lat[6:2], ~lvl_a_n};
    endfunction
    function automatic logic [7:0] e_sta_b();
        return {ser_rx_done, ser_tx_done, ~lvl_b_n};
    endfunction
    function automatic logic [7:0] e_sta_f();
        return {1'b1, ~fiq_lo_n, fiq_hi};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tmr(input int k);
        @(negedge clk); tmr_reload[k] = 1'b1;
        @(negedge clk); tmr_reload = 2'b00;
        m_lat[5+k] = 1'b1;
    endtask

    task automatic check_all();
        rd(5'h04, rv); chk("R11 status A", rv, e_sta_a());
        rd(5'h05, rv); chk("R3 request A", rv, e_sta_a() & m_ma);
        rd(5'h08, rv); chk("R11 status B", rv, e_sta_b());
        rd(5'h09, rv); chk("R3 request B", rv, e_sta_b() & m_mb);
        rd(5'h0C, rv); chk("R12 status F", rv, e_sta_f());
        rd(5'h0D, rv); chk("R3 request F", rv, e_sta_f() & m_mf);
        chk("R4 irq_n", {7'd0, irq_n}, {7'd0, ~(|(e_sta_a() & m_ma) | |(e_sta_b() & m_mb))});
        chk("R5 fiq_n", {7'd0, fiq_n}, {7'd0, ~(|(e_sta_f() & m_mf))});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // reset state
        chk("R4 irq_n reset", {7'd0, irq_n}, 8'd1);
        chk("R5 fiq_n reset", {7'd0, fiq_n}, 8'd1);
        rd(5'h06, rv); chk("R2 mask A reset", rv, 8'h00);
        rd(5'h0A, rv); chk("R2 mask B reset", rv, 8'h00);
        rd(5'h0E, rv); chk("R2 mask F reset", rv, 8'h00);
        rd(5'h04, rv); chk("R8 POR flag after reset", rv, 8'h90);
        rd(5'h00, rv); chk("R13 control levels", rv, 8'h04);
        rd(5'h13, rv); chk("R1 unmapped reads zero", rv, 8'h00);
        // R10: bits 0,1,7 of clear data have no effect, bit4 clears POR
        wr(5'h05, 8'h83);
        rd(5'h04, rv); chk("R10 clear ignores bits 0,1,7", rv, 8'h90);
        wr(5'h05, 8'h10); m_lat[4] = 1'b0;
        rd(5'h04, rv); chk("R8 POR flag cleared", rv, 8'h80);
        // R13: writes to read-only addresses change nothing
        wr(5'h04, 8'hFF); wr(5'h0D, 8'hFF); wr(5'h00, 8'hFF);
        rd(5'h04, rv); chk("R13 status A write ignored", rv, 8'h80);
        rd(5'h0E, rv); chk("R13 mask F untouched", rv, 8'h00);
        rd(5'h00, rv); chk("R13 control write ignored", rv, 8'h04);
        // R6 falling edge, one shot while held low
        @(negedge clk); edge_fall_in = 1'b0;
        wait_n(4); m_lat[2] = 1'b1;
        rd(5'h04, rv); chk("R6 falling edge sets bit 2", rv, 8'h84);
        rd(5'h00, rv); chk("R13 control falling level", rv, 8'h00);
        wr(5'h05, 8'h04); m_lat[2] = 1'b0;
        wait_n(4);
        rd(5'h04, rv); chk("R6 no retrigger while low", rv, 8'h80);
        // R7 rising edge
        @(negedge clk); edge_rise_in = 1'b1;
        wait_n(4); m_lat[3] = 1'b1;
        rd(5'h04, rv); chk("R7 rising edge sets bit 3", rv, 8'h88);
        rd(5'h00, rv); chk("R13 control rising level", rv, 8'h08);
        // R9 timers
        pulse_tmr(0);
        rd(5'h04, rv); chk("R9 timer 0 sets bit 5", rv, 8'hA8);
        pulse_tmr(1);
        rd(5'h04, rv); chk("R9 timer 1 sets bit 6", rv, 8'hE8);
        wr(5'h05, 8'h7C); m_lat = 8'h00;
        rd(5'h04, rv); chk("R10 full clear", rv, 8'h80);
        // R10 set wins over clear in the same cycle
        @(negedge clk); bus_addr = 5'h05; bus_wdata = 8'h20; bus_wr = 1'b1; tmr_reload = 2'b01;
        @(negedge clk); bus_wr = 1'b0; tmr_reload = 2'b00; m_lat[5] = 1'b1;
        rd(5'h04, rv); chk("R10 set beats clear", rv, 8'hA0);
        // R4/R5 directed: always-one bits through masks
        wr(5'h06, 8'h80); m_ma = 8'h80;
        rd(5'h06, rv); chk("R2 mask A readback", rv, 8'h80);
        wait_n(1);
        chk("R4 irq_n on bit 7", {7'd0, irq_n}, 8'd0);
        wr(5'h0E, 8'h80); m_mf = 8'h80;
        wait_n(1);
        chk("R5 fiq_n on bit 7", {7'd0, fiq_n}, 8'd0);
        // constrained random
        for (int it = 0; it < 60; it++) begin
            @(negedge clk);
            lvl_a_n = 2'($urandom); lvl_b_n = 6'($urandom);
            ser_tx_done = 1'($urandom); ser_rx_done = 1'($urandom);
            fiq_hi = 2'($urandom); fiq_lo_n = 5'($urandom);
            m_ma = 8'($urandom); m_mb = 8'($urandom); m_mf = 8'($urandom);
            wr(5'h06, m_ma); wr(5'h0A, m_mb); wr(5'h0E, m_mf);
            if ($urandom % 3 == 0) pulse_tmr(int'($urandom % 2));
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                if (edge_fall_in) m_lat[2] = 1'b1;
                edge_fall_in = ~edge_fall_in;
                wait_n(4);
            end
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                if (!edge_rise_in) m_lat[3] = 1'b1;
                edge_rise_in = ~edge_rise_in;
                wait_n(4);
            end
            if ($urandom % 2 == 0) begin
                rv = 8'($urandom);
                wr(5'h05, rv);
                m_lat = m_lat & ~(rv & 8'h7C);
            end
            wait_n(1);
            check_all();
            rd(5'h0A, rv); chk("R2 mask B readback", rv, m_mb);
            rd(5'h00, rv); chk("R13 control levels", rv, {4'd0, edge_rise_in, edge_fall_in, 2'b00});
        end
        summary();
    end
endmodule